// File: doc/BRIEF.md
# Core Sleep and Performance State Sequencer

This block tracks the power state of a single processor core. The core has one running state and a number of sleep states of increasing depth. Inside the running state it selects one of several performance levels, where level 0 is the fastest. The block accepts three kinds of request: go to sleep at a chosen depth, wake up, and change the performance level. Each accepted request is carried through a timed switching phase. The length of that phase comes from a latency table that software programs through a small write port. There is one table entry per sleep depth for entering, one per sleep depth for leaving, and one per ordered pair of performance levels.

Sleep is only ever entered from the running state and left back to it. A jump from one sleep depth straight to another is refused. When the core goes to sleep, its performance level is saved as a history value, and waking returns to that saved level. While asleep, a performance request does not start a transition; it only rewrites the saved level. Any request that cannot be honoured is dropped and answered with a one-cycle error pulse. The status outputs tell the rest of the chip which state is current, whether the core may run code, and whether a switch is still under way. All status outputs are registered.

Top module: `core_pwr_state_ctrl`

## Requirements
- R1: After reset the block reports running state (cstate 0), performance level 0, history level 0, not busy, execution enabled, and no error.
- R2: exec_en is high only when cstate is 0 and no transition is in progress. It is low for every cycle of a transition and, when the transition completes, it becomes high exactly when the final cstate is 0.
- R3: A sleep request with depth d (1..N_SLEEP) made while running and idle moves cstate to d, copies the current performance level into history, and holds busy for L+1 cycles, where L is the entry latency of depth d.
- R4: A sleep request made while asleep, or with depth 0 or depth above N_SLEEP, is refused and leaves cstate unchanged.
- R5: A wake request made while asleep and idle sets cstate to 0 and the performance level to the history value, and holds busy for L+1 cycles, where L is the exit latency of the depth being left. A wake request made while running is refused.
- R6: A performance request to level j made while running and idle at level i sets the performance level to j and holds busy for L+1 cycles, where L is the pair latency (i, j). This includes the case i equal to j.
- R7: While asleep and idle, a performance request to a valid level rewrites history and raises neither busy nor error. A level of N_PERF or above is refused in any state.
- R8: Any request presented while busy is high is refused and leaves the state unchanged. This includes a request in the last busy cycle.
- R9: If more than one of sleep_req, wake_req and perf_req is high in the same cycle, all of them are refused.
- R10: The latency port writes the entry table with cfg_tbl=0 at index d-1, the exit table with cfg_tbl=1 at index d-1, and the pair table with cfg_tbl=2 at index i*N_PERF+j. A transition accepted in the same cycle as a write to the entry it uses takes the old value; later transitions take the new value.
- R11: Each refused request raises req_err for exactly the one cycle that follows the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Latency table write strobe |
| cfg_tbl | input | 2 | Table select: 0 entry, 1 exit, 2 pair |
| cfg_idx | input | IDX_W | Table index |
| cfg_lat | input | LAT_W | Latency value in cycles |
| sleep_req | input | 1 | Request to enter a sleep state |
| sleep_sel | input | CS_W | Requested sleep depth |
| wake_req | input | 1 | Request to return to the running state |
| perf_req | input | 1 | Request for a performance level |
| perf_sel | input | PS_W | Requested performance level |
| cstate_o | output | CS_W | Current state: 0 running, d sleep depth |
| pstate_o | output | PS_W | Current performance level |
| hist_o | output | PS_W | Saved performance level used on wake |
| busy_o | output | 1 | Transition in progress |
| exec_en_o | output | 1 | Core may execute |
| req_err_o | output | 1 | Refused-request pulse |

## Verification
Two collisions are forced on purpose. In the first, a latency write to the entry table and a sleep request that reads the same entry are driven in one cycle. The scoreboard expects the transition to last for the old value, and expects the following sleep to the same depth to last for the new one. In the second, a request is placed on the last busy cycle, when the counter is at zero and the switch is ending. This request must come back as an error pulse and must not start a second transition, and the monitor checks this through the error queue and the busy-cycle count of the transition that was in progress.

// File: rtl/cpsc_pkg.sv
package cpsc_pkg;
  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_ERR,
    ACT_SLEEP,
    ACT_WAKE,
    ACT_PERF,
    ACT_HIST
  } act_e;

  localparam logic [1:0] TBL_ENTRY = 2'd0;
  localparam logic [1:0] TBL_EXIT  = 2'd1;
  localparam logic [1:0] TBL_PAIR  = 2'd2;

  function automatic int unsigned idx_width(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/cpsc_lat_table.sv
module cpsc_lat_table #(
  parameter int DEPTH = 3,
  parameter int AW    = 2,
  parameter int W     = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && ({1'b0, waddr} < (AW+1)'(DEPTH))) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/cpsc_down_counter.sv
module cpsc_down_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         busy_o,
  output logic         last_o
);
  logic         busy_q;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= load_val;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign last_o = busy_q && (cnt_q == '0);

  // R6: a running count steps down by one each cycle and stays busy
  a_r6_count_step: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));

  // R8: the arbiter never starts a transition while one is running
  a_r8_no_load_busy: assert property (@(posedge clk) disable iff (rst)
    load |-> !busy_q);
endmodule

// File: rtl/cpsc_req_arbiter.sv
module cpsc_req_arbiter
  import cpsc_pkg::*;
#(
  parameter int N_SLEEP = 3,
  parameter int N_PERF  = 3,
  parameter int CS_W    = 2,
  parameter int PS_W    = 2
) (
  input  logic            sleep_req,
  input  logic [CS_W-1:0] sleep_sel,
  input  logic            wake_req,
  input  logic            perf_req,
  input  logic [PS_W-1:0] perf_sel,
  input  logic [CS_W-1:0] cst_i,
  input  logic            busy_i,
  output act_e            act_o
);
  logic [1:0] n_req;
  logic       asleep;
  logic       depth_ok;
  logic       level_ok;

  always_comb begin
    n_req    = {1'b0, sleep_req} + {1'b0, wake_req} + {1'b0, perf_req};
    asleep   = (cst_i != '0);
    depth_ok = (sleep_sel != '0) && ({1'b0, sleep_sel} <= (CS_W+1)'(N_SLEEP));
    level_ok = ({1'b0, perf_sel} < (PS_W+1)'(N_PERF));
    act_o    = ACT_NONE;
    if (n_req != 2'd0) begin
      if (busy_i || n_req != 2'd1) begin
        act_o = ACT_ERR;
      end else if (sleep_req) begin
        act_o = (asleep || !depth_ok) ? ACT_ERR : ACT_SLEEP;
      end else if (wake_req) begin
        act_o = asleep ? ACT_WAKE : ACT_ERR;
      end else if (!level_ok) begin
        act_o = ACT_ERR;
      end else begin
        act_o = asleep ? ACT_HIST : ACT_PERF;
      end
    end
  end
endmodule

// File: rtl/core_pwr_state_ctrl.sv
module core_pwr_state_ctrl
  import cpsc_pkg::*;
#(
  parameter int N_SLEEP = 3,
  parameter int N_PERF  = 3,
  parameter int LAT_W   = 8,
  localparam int CS_W   = $clog2(N_SLEEP + 1),
  localparam int PS_W   = idx_width(N_PERF),
  localparam int SAW    = idx_width(N_SLEEP),
  localparam int PAW    = idx_width(N_PERF * N_PERF),
  localparam int IDX_W  = (SAW > PAW) ? SAW : PAW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_tbl,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [LAT_W-1:0] cfg_lat,
  input  logic             sleep_req,
  input  logic [CS_W-1:0]  sleep_sel,
  input  logic             wake_req,
  input  logic             perf_req,
  input  logic [PS_W-1:0]  perf_sel,
  output logic [CS_W-1:0]  cstate_o,
  output logic [PS_W-1:0]  pstate_o,
  output logic [PS_W-1:0]  hist_o,
  output logic             busy_o,
  output logic             exec_en_o,
  output logic             req_err_o
);
  logic [CS_W-1:0]  cst_q;
  logic [PS_W-1:0]  pst_q;
  logic [PS_W-1:0]  hist_q;
  logic             exec_q;
  logic             err_q;
  logic             busy;
  logic             last;
  act_e             act;
  logic             load;
  logic [LAT_W-1:0] load_val;
  logic [CS_W-1:0]  sel_m1;
  logic [CS_W-1:0]  cst_m1;
  logic [PAW-1:0]   pair_raddr;
  logic [LAT_W-1:0] ent_lat;
  logic [LAT_W-1:0] ext_lat;
  logic [LAT_W-1:0] pair_lat;

  cpsc_req_arbiter #(
    .N_SLEEP(N_SLEEP), .N_PERF(N_PERF), .CS_W(CS_W), .PS_W(PS_W)
  ) u_arb (
    .sleep_req(sleep_req), .sleep_sel(sleep_sel), .wake_req(wake_req),
    .perf_req(perf_req), .perf_sel(perf_sel), .cst_i(cst_q),
    .busy_i(busy), .act_o(act)
  );

  assign sel_m1     = sleep_sel - CS_W'(1);
  assign cst_m1     = cst_q - CS_W'(1);
  assign pair_raddr = PAW'(pst_q) * PAW'(N_PERF) + PAW'(perf_sel);

  cpsc_lat_table #(.DEPTH(N_SLEEP), .AW(SAW), .W(LAT_W)) u_ent_tbl (
    .clk(clk), .we(cfg_we && cfg_tbl == TBL_ENTRY), .waddr(cfg_idx[SAW-1:0]),
    .wdata(cfg_lat), .raddr(sel_m1[SAW-1:0]), .rdata(ent_lat)
  );

  cpsc_lat_table #(.DEPTH(N_SLEEP), .AW(SAW), .W(LAT_W)) u_ext_tbl (
    .clk(clk), .we(cfg_we && cfg_tbl == TBL_EXIT), .waddr(cfg_idx[SAW-1:0]),
    .wdata(cfg_lat), .raddr(cst_m1[SAW-1:0]), .rdata(ext_lat)
  );

  cpsc_lat_table #(.DEPTH(N_PERF * N_PERF), .AW(PAW), .W(LAT_W)) u_pair_tbl (
    .clk(clk), .we(cfg_we && cfg_tbl == TBL_PAIR), .waddr(cfg_idx[PAW-1:0]),
    .wdata(cfg_lat), .raddr(pair_raddr), .rdata(pair_lat)
  );

  always_comb begin
    load = (act == ACT_SLEEP) || (act == ACT_WAKE) || (act == ACT_PERF);
    case (act)
      ACT_SLEEP: load_val = ent_lat;
      ACT_WAKE:  load_val = ext_lat;
      default:   load_val = pair_lat;
    endcase
  end

  cpsc_down_counter #(.W(LAT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val),
    .busy_o(busy), .last_o(last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cst_q  <= '0;
      pst_q  <= '0;
      hist_q <= '0;
      exec_q <= 1'b1;
      err_q  <= 1'b0;
    end else begin
      err_q <= (act == ACT_ERR);
      case (act)
        ACT_SLEEP: begin
          cst_q  <= sleep_sel;
          hist_q <= pst_q;
          exec_q <= 1'b0;
        end
        ACT_WAKE: begin
          cst_q  <= '0;
          pst_q  <= hist_q;
          exec_q <= 1'b0;
        end
        ACT_PERF: begin
          pst_q  <= perf_sel;
          exec_q <= 1'b0;
        end
        ACT_HIST: hist_q <= perf_sel;
        default: begin
          if (last) exec_q <= (cst_q == '0);
        end
      endcase
    end
  end

  assign cstate_o  = cst_q;
  assign pstate_o  = pst_q;
  assign hist_o    = hist_q;
  assign busy_o    = busy;
  assign exec_en_o = exec_q;
  assign req_err_o = err_q;

  // R2: execution is enabled only when running with no switch under way
  a_r2_exec_idle_run: assert property (@(posedge clk) disable iff (rst)
    exec_q |-> (cst_q == '0 && !busy));

  // R4: a sleep depth is only ever left towards the running state
  a_r4_no_sleep_hop: assert property (@(posedge clk) disable iff (rst)
    (cst_q != '0) |=> (cst_q == '0 || $stable(cst_q)));

  // R5: arriving in the running state restores the saved level
  a_r5_wake_restore: assert property (@(posedge clk) disable iff (rst)
    ($past(cst_q) != '0 && cst_q == '0) |-> (pst_q == $past(hist_q)));

  // R8: a refused request leaves the visible state untouched
  a_r8_err_freeze: assert property (@(posedge clk) disable iff (rst)
    err_q |-> ($stable(cst_q) && $stable(pst_q) && $stable(hist_q)));
endmodule

// File: tb/core_pwr_state_ctrl_tb.sv
module core_pwr_state_ctrl_tb;
  localparam int NS  = 3;
  localparam int NP  = 3;
  localparam int LW  = 8;
  localparam int CSW = 2;
  localparam int PSW = 2;
  localparam int IW  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic           cfg_we = 1'b0;
  logic [1:0]     cfg_tbl = '0;
  logic [IW-1:0]  cfg_idx = '0;
  logic [LW-1:0]  cfg_lat = '0;
  logic           sleep_req = 1'b0;
  logic [CSW-1:0] sleep_sel = '0;
  logic           wake_req = 1'b0;
  logic           perf_req = 1'b0;
  logic [PSW-1:0] perf_sel = '0;
  logic [CSW-1:0] cstate_o;
  logic [PSW-1:0] pstate_o;
  logic [PSW-1:0] hist_o;
  logic           busy_o;
  logic           exec_en_o;
  logic           req_err_o;

  core_pwr_state_ctrl #(.N_SLEEP(NS), .N_PERF(NP), .LAT_W(LW)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_tbl(cfg_tbl), .cfg_idx(cfg_idx),
    .cfg_lat(cfg_lat), .sleep_req(sleep_req), .sleep_sel(sleep_sel),
    .wake_req(wake_req), .perf_req(perf_req), .perf_sel(perf_sel),
    .cstate_o(cstate_o), .pstate_o(pstate_o), .hist_o(hist_o),
    .busy_o(busy_o), .exec_en_o(exec_en_o), .req_err_o(req_err_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    string r;
    int    c;
    int    p;
    int    h;
    int    lat;
  } item_t;

  item_t tq[$];
  string eq[$];
  int ent_m[NS];
  int ext_m[NS];
  int pair_m[NP*NP];
  int m_c = 0;
  int m_p = 0;
  int m_h = 0;

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  // monitor: measures each transition and pops the scoreboard
  bit in_tr    = 1'b0;
  int bcnt     = 0;
  bit exec_bad = 1'b0;
  always @(negedge clk) begin
    item_t it;
    string s;
    if (!rst) begin
      if (busy_o) begin
        if (!in_tr) begin
          in_tr    = 1'b1;
          bcnt     = 0;
          exec_bad = 1'b0;
        end
        bcnt++;
        if (exec_en_o) exec_bad = 1'b1;
      end else if (in_tr) begin
        in_tr = 1'b0;
        if (tq.size() == 0) begin
          chk("R8 unexpected transition", 1, 0);
        end else begin
          it = tq.pop_front();
          chk({it.r, " busy cycles"}, bcnt, it.lat + 1);
          chk({it.r, " cstate"}, int'(cstate_o), it.c);
          chk({it.r, " pstate"}, int'(pstate_o), it.p);
          chk({it.r, " hist"}, int'(hist_o), it.h);
          chk({"R2 exec low during ", it.r}, int'(exec_bad), 0);
          chk({"R2 exec after ", it.r}, int'(exec_en_o), (it.c == 0) ? 1 : 0);
        end
      end
      if (req_err_o) begin
        if (eq.size() == 0) begin
          chk("R11 unexpected error pulse", 1, 0);
        end else begin
          s = eq.pop_front();
          chk({"R11 error pulse for ", s}, 1, 1);
        end
      end
    end
  end

  task automatic cfg_wr(int t, int i, int v);
    cfg_we = 1'b1; cfg_tbl = 2'(t); cfg_idx = IW'(i); cfg_lat = LW'(v);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_sleep(int d, bit bad, string r);
    item_t it;
    sleep_req = 1'b1; sleep_sel = CSW'(d);
    if (bad) eq.push_back(r);
    else begin
      m_h = m_p; m_c = d;
      it.r = r; it.c = m_c; it.p = m_p; it.h = m_h; it.lat = ent_m[d-1];
      tq.push_back(it);
    end
    @(negedge clk);
    sleep_req = 1'b0;
  endtask

  task automatic do_wake(bit bad, string r);
    item_t it;
    wake_req = 1'b1;
    if (bad) eq.push_back(r);
    else begin
      it.lat = ext_m[m_c-1];
      m_c = 0; m_p = m_h;
      it.r = r; it.c = m_c; it.p = m_p; it.h = m_h;
      tq.push_back(it);
    end
    @(negedge clk);
    wake_req = 1'b0;
  endtask

  task automatic do_perf(int l, bit bad, string r);
    item_t it;
    perf_req = 1'b1; perf_sel = PSW'(l);
    if (bad) eq.push_back(r);
    else if (m_c == 0) begin
      it.lat = pair_m[m_p*NP + l];
      m_p = l;
      it.r = r; it.c = m_c; it.p = m_p; it.h = m_h;
      tq.push_back(it);
    end else begin
      m_h = l;
    end
    @(negedge clk);
    perf_req = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: state right after reset
    chk("R1 cstate", int'(cstate_o), 0);
    chk("R1 pstate", int'(pstate_o), 0);
    chk("R1 hist", int'(hist_o), 0);
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 exec_en", int'(exec_en_o), 1);
    chk("R1 req_err", int'(req_err_o), 0);

    // R10: program every table entry
    ent_m = '{0, 3, 5};
    ext_m = '{2, 4, 1};
    for (int i = 0; i < NS; i++) begin
      cfg_wr(0, i, ent_m[i]);
      cfg_wr(1, i, ext_m[i]);
    end
    for (int i = 0; i < NP; i++) begin
      for (int j = 0; j < NP; j++) begin
        pair_m[i*NP + j] = i + 2*j;
        cfg_wr(2, i*NP + j, pair_m[i*NP + j]);
      end
    end

    do_perf(2, 1'b0, "R6 level 0 to 2"); wait_idle();
    do_perf(1, 1'b0, "R6 level 2 to 1"); wait_idle();
    do_sleep(2, 1'b0, "R3 sleep depth 2"); wait_idle();
    chk("R3 history holds level", int'(hist_o), 1);

    do_sleep(3, 1'b1, "R4 sleep to sleep");
    chk("R4 cstate kept", int'(cstate_o), 2);

    do_perf(0, 1'b0, "R7 history rewrite");
    chk("R7 hist rewritten", int'(hist_o), 0);
    chk("R7 no busy", int'(busy_o), 0);
    chk("R7 no error", int'(req_err_o), 0);
    do_perf(3, 1'b1, "R7 invalid level");

    do_wake(1'b0, "R5 wake from depth 2"); wait_idle();
    do_wake(1'b1, "R5 wake while running");
    do_sleep(0, 1'b1, "R4 depth zero");
    do_sleep(1, 1'b0, "R3 zero latency depth 1"); wait_idle();

    // R8: requests in the middle and the last busy cycle
    do_wake(1'b0, "R5 wake from depth 1");
    do_perf(1, 1'b1, "R8 mid transition");
    @(negedge clk);
    do_sleep(2, 1'b1, "R8 last busy cycle");
    wait_idle();

    // R9: two requests at once
    sleep_req = 1'b1; sleep_sel = 2'd1; perf_req = 1'b1; perf_sel = 2'd1;
    eq.push_back("R9 dual request");
    @(negedge clk);
    sleep_req = 1'b0; perf_req = 1'b0;
    chk("R9 cstate kept", int'(cstate_o), 0);
    chk("R9 pstate kept", int'(pstate_o), 0);

    // R10: write collides with a transition reading the same entry
    cfg_we = 1'b1; cfg_tbl = 2'd0; cfg_idx = 4'd2; cfg_lat = 8'd7;
    do_sleep(3, 1'b0, "R10 old latency on collision");
    cfg_we = 1'b0;
    ent_m[2] = 7;
    wait_idle();
    do_wake(1'b0, "R5 wake from depth 3"); wait_idle();
    do_sleep(3, 1'b0, "R10 new latency after write"); wait_idle();
    do_wake(1'b0, "R5 wake again"); wait_idle();
    do_perf(0, 1'b0, "R6 same level zero latency"); wait_idle();

    repeat (3) @(negedge clk);
    chk("R8 transition queue drained", tq.size(), 0);
    chk("R11 error queue drained", eq.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule